// File: doc/BRIEF.md
# Clock Output Bank Divider with Type-Aware Gating

This block forms one output bank of a multi-output clock generator. It divides the high-rate synthesizer clock by a programmable integer ratio and drives a pair of logic-level outputs, A and B. The bank runs in one of two output types. In single-ended type, A and B carry the same waveform. In differential type, B is always the inverse of A.

The bank can be disabled, or held at a static level on request. The level it holds at depends on the output type. A bypass path routes a reference clock straight to the pair, with the reference's own frequency and duty cycle. Changes to the ratio, type, enable and static request are held back until the divider reaches the end of its current period, so no output pulse is ever cut short.

Banks built from this block run from separate counters, and no phase relationship between banks is implied. A synchronous reset leaves the pair in the static differential state.

Top module: `clkbank_out`

## Requirements
- R1: While reset is asserted, and until the divider first reaches terminal count after reset, out_a is 0 and out_b is 1.
- R2: For an active ratio N, out_a repeats every N clock cycles. It is high for floor(N/2) cycles and low for N minus floor(N/2) cycles, so for odd N the high phase is one cycle shorter than the low phase.
- R3: In single-ended type (kind_sel = 0), enabled and not held, out_b equals out_a in every cycle.
- R4: In differential type (kind_sel = 1), out_b is the complement of out_a in every state, whether running, disabled, held or bypassed.
- R5: When disabled (out_en = 0) in single-ended type, out_a and out_b are both 0.
- R6: When disabled in differential type, out_a is 0 and out_b is 1.
- R7: When hold_static is 1, out_a is 0 and out_b is 1, whatever the type and enable.
- R8: A new ratio, type, enable or hold value is taken only at terminal count, which is the last cycle of the current period. Every completed high or low run therefore has the length of either the old ratio or the new ratio.
- R9: When bypass_sel is 1 and the bank is enabled and not held, out_a follows ref_clk without a register, and out_b follows ref_clk (single-ended) or its inverse (differential). Frequency and duty cycle equal those of ref_clk. Disable and hold still override bypass.
- R10: A requested ratio of 0 or 1 is treated as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Synthesizer clock that is divided |
| rst | input | 1 | Synchronous reset, active high |
| div_ratio | input | DIV_W | Requested integer divide ratio |
| kind_sel | input | 1 | Output type: 0 single-ended pair, 1 differential pair |
| out_en | input | 1 | Output enable request |
| hold_static | input | 1 | Request to hold the static differential level |
| bypass_sel | input | 1 | Route ref_clk to the outputs instead of the divided clock |
| ref_clk | input | 1 | Reference clock for the bypass path |
| out_a | output | 1 | Output A (true) |
| out_b | output | 1 | Output B (copy or complement) |

## Verification
Control changes reach the outputs at the next terminal count, which comes at most N cycles after the change. Each output change then appears one register after that terminal edge. The bench therefore waits longer than the old period plus two cycles before it measures a new steady pattern. In windows that cross a change, it checks only complete runs, against both the old and the new lengths. Run lengths are measured on the falling clock edge, so the register timing never affects the count. The bypass path has no register, so it is sampled a few nanoseconds after each reference edge, and its duty cycle is checked from the times of the out_a edges.

// File: rtl/clkbank_pkg.sv
package clkbank_pkg;

   typedef enum logic {
      KIND_SE   = 1'b0,
      KIND_DIFF = 1'b1
   } bank_kind_e;

   typedef struct packed {
      logic       en;
      logic       hold;
      bank_kind_e kind;
   } bank_mode_t;

   localparam bank_mode_t MODE_RESET = '{en: 1'b0, hold: 1'b1, kind: KIND_DIFF};

endpackage

// File: rtl/clkbank_shadow.sv
module clkbank_shadow
   import clkbank_pkg::*;
#(
   parameter int DIV_W     = 4,
   parameter int MIN_RATIO = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tc,
   input  logic [DIV_W-1:0] req_ratio,
   input  bank_mode_t       req_mode,
   output logic [DIV_W-1:0] ratio_q,
   output bank_mode_t       mode_q
);
   localparam logic [DIV_W-1:0] RATIO_FLOOR = DIV_W'(MIN_RATIO);

   logic [DIV_W-1:0] ratio_clamped;

   always_comb begin
      if (req_ratio < RATIO_FLOOR) ratio_clamped = RATIO_FLOOR;
      else                         ratio_clamped = req_ratio;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ratio_q <= RATIO_FLOOR;
         mode_q  <= MODE_RESET;
      end else if (tc) begin
         ratio_q <= ratio_clamped;
         mode_q  <= req_mode;
      end
   end
endmodule

// File: rtl/clkbank_divcnt.sv
module clkbank_divcnt #(
   parameter int DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [DIV_W-1:0] ratio_q,
   output logic             tc,
   output logic [DIV_W-1:0] cnt_q,
   output logic             phase_q
);
   logic [DIV_W-1:0] cnt_inc;
   logic [DIV_W-1:0] half_ratio;
   logic             phase_d;

   assign cnt_inc    = cnt_q + 1'b1;
   assign half_ratio = ratio_q >> 1;
   assign tc         = (cnt_inc == ratio_q);

   always_comb begin
      if (tc) phase_d = 1'b1;
      else    phase_d = (cnt_inc < half_ratio);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q   <= '0;
         phase_q <= 1'b0;
      end else begin
         cnt_q   <= tc ? '0 : cnt_inc;
         phase_q <= phase_d;
      end
   end
endmodule

// File: rtl/clkbank_drive.sv
module clkbank_drive
   import clkbank_pkg::*;
#(
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic       phase_q,
   input  logic       ref_clk,
   input  logic       bypass_sel,
   input  bank_mode_t mode_q,
   output logic       out_a,
   output logic       out_b
);
   logic src;

   generate
      if (BYPASS_EN) begin : g_byp
         assign src = bypass_sel ? ref_clk : phase_q;
      end else begin : g_nobyp
         logic unused_byp;
         assign unused_byp = bypass_sel ^ ref_clk;
         assign src = phase_q;
      end
   endgenerate

   always_comb begin
      if (mode_q.hold) begin
         out_a = 1'b0;
         out_b = 1'b1;
      end else if (!mode_q.en) begin
         out_a = 1'b0;
         out_b = (mode_q.kind == KIND_DIFF);
      end else begin
         out_a = src;
         out_b = (mode_q.kind == KIND_DIFF) ? ~src : src;
      end
   end
endmodule

// File: rtl/clkbank_out.sv
module clkbank_out
   import clkbank_pkg::*;
#(
   parameter int DIV_W     = 4,
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [DIV_W-1:0] div_ratio,
   input  logic             kind_sel,
   input  logic             out_en,
   input  logic             hold_static,
   input  logic             bypass_sel,
   input  logic             ref_clk,
   output logic             out_a,
   output logic             out_b
);
   localparam int MIN_RATIO = 2;

   generate
      if (DIV_W < 2) begin : g_bad_width
         $error("clkbank_out: DIV_W must be at least 2");
      end
   endgenerate

   bank_mode_t       req_mode;
   bank_mode_t       mode_q;
   logic [DIV_W-1:0] ratio_q;
   logic [DIV_W-1:0] cnt_q;
   logic             tc;
   logic             phase_q;

   assign req_mode = '{en: out_en, hold: hold_static, kind: bank_kind_e'(kind_sel)};

   clkbank_shadow #(.DIV_W(DIV_W), .MIN_RATIO(MIN_RATIO)) u_shadow (
      .clk       (clk),
      .rst       (rst),
      .tc        (tc),
      .req_ratio (div_ratio),
      .req_mode  (req_mode),
      .ratio_q   (ratio_q),
      .mode_q    (mode_q)
   );

   clkbank_divcnt #(.DIV_W(DIV_W)) u_div (
      .clk     (clk),
      .rst     (rst),
      .ratio_q (ratio_q),
      .tc      (tc),
      .cnt_q   (cnt_q),
      .phase_q (phase_q)
   );

   clkbank_drive #(.BYPASS_EN(BYPASS_EN)) u_drive (
      .phase_q    (phase_q),
      .ref_clk    (ref_clk),
      .bypass_sel (bypass_sel),
      .mode_q     (mode_q),
      .out_a      (out_a),
      .out_b      (out_b)
   );
endmodule

// File: rtl/clkbank_out_chk.sv
module clkbank_out_chk
   import clkbank_pkg::*;
#(
   parameter int DIV_W = 4
) (
   input logic             clk,
   input logic             rst,
   input logic             out_a,
   input logic             out_b,
   input logic             tc,
   input logic [DIV_W-1:0] cnt_q,
   input logic [DIV_W-1:0] ratio_q,
   input bank_mode_t       mode_q
);
   p_static_levels_r7: assert property (@(posedge clk) disable iff (rst)
      mode_q.hold |-> (!out_a && out_b));

   p_se_disabled_low_r5: assert property (@(posedge clk) disable iff (rst)
      (!mode_q.hold && !mode_q.en && mode_q.kind == KIND_SE) |-> (!out_a && !out_b));

   p_diff_complement_r4: assert property (@(posedge clk) disable iff (rst)
      (mode_q.kind == KIND_DIFF) |-> (out_a != out_b));

   p_se_in_phase_r3: assert property (@(posedge clk) disable iff (rst)
      (mode_q.kind == KIND_SE && mode_q.en && !mode_q.hold) |-> (out_a == out_b));

   p_cfg_only_at_tc_r8: assert property (@(posedge clk) disable iff (rst)
      !tc |=> ($stable(ratio_q) && $stable(mode_q)));

   p_count_in_period_r2: assert property (@(posedge clk) disable iff (rst)
      cnt_q < ratio_q);

   p_ratio_floor_r10: assert property (@(posedge clk) disable iff (rst)
      ratio_q >= DIV_W'(2));
endmodule

bind clkbank_out clkbank_out_chk #(.DIV_W(DIV_W)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .out_a   (out_a),
   .out_b   (out_b),
   .tc      (tc),
   .cnt_q   (cnt_q),
   .ratio_q (ratio_q),
   .mode_q  (mode_q)
);

// File: tb/clkbank_out_test.sv
`timescale 1ns/1ps
module clkbank_out_test;
   localparam int DIV_W = 4;
   localparam int MAXR  = (1 << DIV_W) - 1;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic [DIV_W-1:0] div_ratio = 4'd2;
   logic             kind_sel = 1'b0;
   logic             out_en = 1'b0;
   logic             hold_static = 1'b0;
   logic             bypass_sel = 1'b0;
   logic             ref_clk = 1'b0;
   logic             out_a, out_b;

   int  n_vec = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;
   int  cur_ratio = 2;

   clkbank_out #(.DIV_W(DIV_W)) uut (
      .clk(clk), .rst(rst), .div_ratio(div_ratio), .kind_sel(kind_sel),
      .out_en(out_en), .hold_static(hold_static), .bypass_sel(bypass_sel),
      .ref_clk(ref_clk), .out_a(out_a), .out_b(out_b)
   );

   always #4 clk = ~clk;

   initial begin
      #3;
      forever begin
         ref_clk = 1'b1; #9;
         ref_clk = 1'b0; #14;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int eff(input int n);
      return (n < 2) ? 2 : n;
   endfunction

   task automatic pair_check();
      if (kind_sel) check(out_b == ~out_a, "R4 complement", int'(out_b), int'(~out_a));
      else          check(out_b == out_a,  "R3 in-phase",   int'(out_b), int'(out_a));
   endtask

   // measure complete runs of out_a; each must match one of the two allowed lengths
   task automatic run_window(input int cyc, input int h1, input int l1,
                             input int h2, input int l2, input string tag);
      logic prev;
      int   run;
      bit   first;
      @(negedge clk);
      prev = out_a; run = 1; first = 1'b1;
      pair_check();
      for (int i = 1; i < cyc; i++) begin
         @(negedge clk);
         pair_check();
         if (out_a == prev) run++;
         else begin
            if (!first) begin
               if (prev) check(run == h1 || run == h2, {tag, " high run"}, run, h1);
               else      check(run == l1 || run == l2, {tag, " low run"},  run, l1);
            end
            first = 1'b0;
            prev  = out_a;
            run   = 1;
         end
      end
   endtask

   task automatic set_ratio_steady(input int n, input string tag);
      int old_n, ne, hi;
      old_n = eff(cur_ratio);
      div_ratio = DIV_W'(n);
      cur_ratio = n;
      ne = eff(n);
      hi = ne / 2;
      repeat (old_n + 2) @(negedge clk);
      run_window(4 * ne + 2, hi, ne - hi, hi, ne - hi, tag);
   endtask

   task automatic wait_static(input int a_exp, input int b_exp, input string tag);
      repeat (eff(cur_ratio) + 2) @(negedge clk);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check(out_a == a_exp[0], {tag, " out_a"}, int'(out_a), a_exp);
         check(out_b == b_exp[0], {tag, " out_b"}, int'(out_b), b_exp);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      realtime t0, t1, t2;
      // R1: reset state
      repeat (4) begin
         @(negedge clk);
         check(!out_a && out_b, "R1 reset level", {out_a, out_b}, 1);
      end
      rst = 1'b0;
      @(negedge clk);
      check(!out_a && out_b, "R1 before first terminal count", {out_a, out_b}, 1);
      // R5: first load with enable off in single-ended type
      wait_static(0, 0, "R5 disabled single-ended");

      // R2 / R10 / R4: ratio sweep, differential type
      kind_sel = 1'b1; out_en = 1'b1;
      for (int n = 0; n <= MAXR; n++) set_ratio_steady(n, "R2 R10 diff sweep");
      // R2 / R3: ratio sweep, single-ended type
      kind_sel = 1'b0;
      for (int n = MAXR; n >= 0; n--) set_ratio_steady(n, "R2 R10 se sweep");

      // R8: ratio change mid-period, both directions
      set_ratio_steady(4, "R8 pre");
      div_ratio = 4'd7; cur_ratio = 7;
      run_window(40, 2, 2, 3, 4, "R8 ratio 4 to 7");
      set_ratio_steady(9, "R8 pre");
      repeat (3) @(negedge clk);
      div_ratio = 4'd2; cur_ratio = 2;
      run_window(30, 4, 5, 1, 1, "R8 ratio 9 to 2");

      // R8 + R5: disable mid-period keeps full runs, then low pair
      set_ratio_steady(6, "R8 pre");
      repeat (2) @(negedge clk);
      out_en = 1'b0;
      run_window(20, 3, 3, 3, 3, "R8 disable");
      wait_static(0, 0, "R5 disabled single-ended");
      // R6: disabled differential
      kind_sel = 1'b1;
      wait_static(0, 1, "R6 disabled differential");
      out_en = 1'b1;
      run_window(30, 3, 3, 3, 3, "R8 re-enable");

      // R7: hold in both types, with enable on
      hold_static = 1'b1;
      wait_static(0, 1, "R7 hold differential");
      kind_sel = 1'b0;
      wait_static(0, 1, "R7 hold single-ended");
      hold_static = 1'b0;
      repeat (8) @(negedge clk);
      run_window(30, 3, 3, 3, 3, "R7 release");

      // R9: bypass path
      bypass_sel = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(posedge ref_clk); #2;
         check(out_a && out_b, "R9 bypass se high", {out_a, out_b}, 3);
         @(negedge ref_clk); #2;
         check(!out_a && !out_b, "R9 bypass se low", {out_a, out_b}, 0);
      end
      @(posedge out_a); t0 = $realtime;
      @(negedge out_a); t1 = $realtime;
      @(posedge out_a); t2 = $realtime;
      check((t1 - t0) == 9.0,  "R9 bypass high time", int'(t1 - t0), 9);
      check((t2 - t0) == 23.0, "R9 bypass period",    int'(t2 - t0), 23);
      kind_sel = 1'b1;
      repeat (10) @(negedge clk);
      for (int i = 0; i < 6; i++) begin
         @(posedge ref_clk); #2;
         check(out_a && !out_b, "R9 bypass diff high", {out_a, out_b}, 2);
         @(negedge ref_clk); #2;
         check(!out_a && out_b, "R9 bypass diff low", {out_a, out_b}, 1);
      end
      hold_static = 1'b1;
      repeat (10) @(negedge clk);
      for (int i = 0; i < 4; i++) begin
         @(posedge ref_clk); #2;
         check(!out_a && out_b, "R9 R7 hold overrides bypass", {out_a, out_b}, 1);
      end
      hold_static = 1'b0; kind_sel = 1'b0; out_en = 1'b0;
      repeat (10) @(negedge clk);
      for (int i = 0; i < 4; i++) begin
         @(posedge ref_clk); #2;
         check(!out_a && !out_b, "R9 R5 disable overrides bypass", {out_a, out_b}, 0);
      end

      // R1: reset mid-run returns to static differential level
      bypass_sel = 1'b0; out_en = 1'b1;
      repeat (10) @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      check(!out_a && out_b, "R1 reset mid-run", {out_a, out_b}, 1);
      rst = 1'b0;

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule